// File: doc/BRIEF.md
# Long-Press Global Reset Timer

This block watches an active-low reset button input and decides when a long press should restart the whole system. It runs on a slow always-on clock (nominally 32.768 kHz). The input goes through a two-flop synchronizer. The block then counts how many consecutive slow-clock samples it sees low. When the press has lasted at least the selected hold time and the input then returns high, the block issues a one-cycle restart request. The power sequencer uses that request to power the system down and back up.

One cycle after the request, the block pulses a per-group register-default load vector. A fixed mask keeps some groups out of this load. By default these are the real-time clock group and the group that holds the protected bit, so they keep their contents across the restart. The hold time comes from a 2-bit select supplied by the configuration register file. One code of that select is invalid and disables the function. A request is also refused unless the battery-good indication is high when the input is released.

Top module: `glb_rst_timer`

## Requirements
- R1: The pin is synchronized by two flops, so a release is seen by the counter two slow-clock edges after the pin rises, and `rst_req` is high in the third cycle after the release.
- R2: The hold threshold in low samples is 4×TICK_HZ for `hold_sel`=01, 8×TICK_HZ for 10 and 12×TICK_HZ for 11. A press of exactly the threshold length qualifies.
- R3: A press shorter than the threshold, followed by a release, produces no `rst_req` and no `load_grp` pulse.
- R4: While `hold_sel`=00, no request is ever issued, however long the press lasts.
- R5: `rst_req` is a single-cycle strobe. It is issued once per qualified press, on the first synchronized high sample, however long the pin was held beyond the threshold.
- R6: If `batt_ok` is low in the cycle in which the release is evaluated, no request is issued.
- R7: `load_grp` is all zero except in the cycle right after `rst_req`. In that cycle it equals the inverse of KEEP_MASK. Bit 7 (real-time clock) and bit 6 (protected bit) are never set by default.
- R8: After reset, `rst_req` and `load_grp` are zero and the counter is clear.
- R9: A high sample before the threshold is reached clears the count, so two short presses separated by a brief release do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_n | input | 1 | Asynchronous active-low reset button input |
| hold_sel | input | 2 | Hold-time select; 00 is invalid |
| batt_ok | input | 1 | Battery above low-battery threshold |
| rst_req | output | 1 | One-cycle full restart request |
| load_grp | output | NGRP | Per-group register-default load strobe |

## Verification
The assertions assume that `hold_sel` and `batt_ok` come from registered, slowly changing sources and are steady around a release. They also assume that `rst_n` is applied before any press. The stimulus changes the select and the battery flag only while the pin has been idle high for several cycles. It changes the pin only on falling clock edges, so the number of low samples is exact. The bench overrides TICK_HZ with a small value so that each threshold is reached in tens of cycles.

// File: rtl/glb_rst_timer.sv
module glb_rst_timer #(
  parameter int TICK_HZ = 32768,
  parameter int NGRP = 8,
  parameter logic [NGRP-1:0] KEEP_MASK = 8'b1100_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            btn_n,
  input  logic [1:0]      hold_sel,
  input  logic            batt_ok,
  output logic            rst_req,
  output logic [NGRP-1:0] load_grp
);
  localparam int CW = $clog2(12 * TICK_HZ + 1);
  localparam logic [CW-1:0] THR4  = CW'(4 * TICK_HZ);
  localparam logic [CW-1:0] THR8  = CW'(8 * TICK_HZ);
  localparam logic [CW-1:0] THR12 = CW'(12 * TICK_HZ);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;
  logic          pin_hi, sel_ok, qual, fire;

  always_comb begin
    case (hold_sel)
      2'b01:   thr = THR4;
      2'b10:   thr = THR8;
      2'b11:   thr = THR12;
      default: thr = '0;
    endcase
  end

  assign pin_hi = sync_q[1];
  assign sel_ok = hold_sel != 2'b00;
  assign qual   = sel_ok && (cnt >= thr);
  assign fire   = pin_hi && qual && batt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], btn_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!sel_ok || pin_hi) cnt <= '0;
    else if (!qual)             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      load_grp <= '0;
    end else begin
      rst_req  <= fire;
      load_grp <= {NGRP{rst_req}} & ~KEEP_MASK;
    end
  end
endmodule

// File: rtl/glb_rst_timer_chk.sv
module glb_rst_timer_chk #(
  parameter int NGRP = 8,
  parameter logic [NGRP-1:0] KEEP_MASK = 8'b1100_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      hold_sel,
  input logic            batt_ok,
  input logic [1:0]      sync_q,
  input logic            rst_req,
  input logic [NGRP-1:0] load_grp
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R5
  AST_LOAD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (load_grp == ~KEEP_MASK)); // R7
  AST_LOAD_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |=> (load_grp == '0)); // R7
  AST_NO_REQ_INVALID_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_sel == 2'b00) |=> !rst_req); // R4
  AST_NO_REQ_LOW_BATT: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_ok |=> !rst_req); // R6
  AST_REQ_ON_HIGH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q[1] |=> !rst_req); // R1
endmodule

bind glb_rst_timer glb_rst_timer_chk #(.NGRP(NGRP), .KEEP_MASK(KEEP_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_sel(hold_sel), .batt_ok(batt_ok),
  .sync_q(sync_q), .rst_req(rst_req), .load_grp(load_grp)
);

// File: tb/glb_rst_timer_bench.sv
module glb_rst_timer_bench;
  localparam int TICK = 8;
  localparam int NG = 8;
  localparam logic [NG-1:0] KEEP = 8'b1100_0000;

  typedef struct { int cyc; logic [NG-1:0] grp; string tag; } exp_t;

  logic clk = 0, rst_n = 0, btn_n = 1, batt_ok = 1;
  logic [1:0] hold_sel = 2'b11;
  logic rst_req;
  logic [NG-1:0] load_grp;
  int cyc = 0, n_cmp = 0, n_bad = 0;
  exp_t expq[$];
  bit done = 0;

  glb_rst_timer #(.TICK_HZ(TICK), .NGRP(NG), .KEEP_MASK(KEEP)) u_glb_rst_timer (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .hold_sel(hold_sel),
    .batt_ok(batt_ok), .rst_req(rst_req), .load_grp(load_grp));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every request pulse pops an expected item
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rst_req) begin
        if (expq.size() == 0) begin
          check(0, "R3/R4/R6 unexpected rst_req", cyc, -1);
        end else begin
          e = expq.pop_front();
          check(cyc == e.cyc, {e.tag, " request cycle"}, cyc, e.cyc);
          @(negedge clk);
          check(load_grp == e.grp, "R7 load_grp", int'(load_grp), int'(e.grp));
          check(!rst_req, "R5 single-cycle strobe", int'(rst_req), 0);
        end
      end else if (rst_n) begin
        if (load_grp != '0) check(0, "R7 load_grp outside request", int'(load_grp), 0);
      end
    end
  end

  task automatic press(int low, bit expect_req, string tag);
    exp_t e;
    @(negedge clk);
    btn_n = 0;
    repeat (low) @(negedge clk);
    btn_n = 1;
    if (expect_req) begin
      e.cyc = cyc + 3; e.grp = ~KEEP; e.tag = tag;
      expq.push_back(e);
    end
    repeat (10) @(negedge clk);
    check(expq.size() == 0, {tag, " missing request"}, expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rst_req == 0 && load_grp == '0, "R8 reset outputs", int'(load_grp), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(rst_req == 0 && load_grp == '0, "R8 idle after reset", int'(rst_req), 0);

    hold_sel = 2'b11;
    press(12*TICK, 1, "R2 sel11 exact");
    press(12*TICK-1, 0, "R3 sel11 short");
    hold_sel = 2'b01;
    press(4*TICK, 1, "R2 sel01 exact");
    press(4*TICK-1, 0, "R3 sel01 short");
    hold_sel = 2'b10;
    press(8*TICK, 1, "R2 sel10 exact");
    press(8*TICK-1, 0, "R3 sel10 short");
    press(8*TICK+50, 1, "R1 sel10 latency");
    hold_sel = 2'b00;
    press(200, 0, "R4 invalid select");
    hold_sel = 2'b01;
    press(300, 1, "R5 long hold saturates");
    batt_ok = 0;
    repeat (4) @(negedge clk);
    press(100, 0, "R6 low battery");
    batt_ok = 1;
    repeat (4) @(negedge clk);
    @(negedge clk); btn_n = 0;
    repeat (20) @(negedge clk); btn_n = 1;
    repeat (2) @(negedge clk);
    press(20, 0, "R9 split press");
    press(4*TICK, 1, "R9 fresh press after split");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
      end
    join_any
    check(expq.size() == 0, "end queue empty", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule